// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against runaway software. A free-running counter advances on tick enables from one of two selectable time bases. When the counter crosses the chosen power-of-two boundary it either asks the reset controller for a system reset (watchdog use) or raises a sticky interrupt flag (periodic interval use). Software services the watchdog by writing a clear request. Software may also freeze the counter to save power.

The single 16-bit control word accepts a write only when its upper byte carries the access key. A write with any other upper byte is treated as a sign of runaway code and triggers a reset request at once. A fail-safe monitor counts ticks of an always-running backup time base. If the selected time base stays silent for too long, the counter moves over to the backup ticks until the selected source shows life again. While the block works as a watchdog on the backup ticks, a freeze request is overridden, so the protection cannot be switched off by a dead clock.

All time bases arrive as single-cycle tick enables in the `clk` domain. The oscillators and the rest of the reset logic sit outside the block.

Top module: `wdt_guard_top`

## Requirements
- R1: After reset, `rd_data` reads 16'h6900, and `rst_req`, `irq_flag` and `on_backup` are low.
- R2: A write updates the control word only when `wr_data[15:8]` is 8'h5A. A read always shows 8'h69 in `rd_data[15:8]`. Control fields: bit 7 freeze, bit 4 mode (1 = interval, 0 = watchdog), bit 3 clear request, bit 2 source select, bits 1:0 period select. All other bits read as zero.
- R3: A write whose upper byte is not 8'h5A drives `rst_req` high for exactly the one cycle after the write edge and leaves the control word unchanged.
- R4: Period select 0, 1, 2 and 3 give an expiry every 2^15, 2^13, 2^9 and 2^6 counted ticks respectively.
- R5: In watchdog mode each expiry produces a one-cycle `rst_req` pulse and leaves `irq_flag` low.
- R6: In interval mode each expiry sets `irq_flag`, which stays high until `irq_ack` is asserted. Expiry never raises `rst_req` in this mode.
- R7: A keyed write with bit 3 set restarts the count from zero. Bit 3 always reads back as zero.
- R8: Source select 0 counts `tick_a` and source select 1 counts `tick_b`.
- R9: With the freeze bit set, and outside the case in R11, the counter does not advance and no expiry occurs.
- R10: If the selected source gives no tick during FS_LIMIT (default 4) consecutive `tick_bk` pulses, `on_backup` goes high and the counter advances on `tick_bk`. The next tick from the selected source drops `on_backup`.
- R11: In watchdog mode with `on_backup` high, the freeze bit is ignored and expiries keep producing resets. In interval mode the freeze bit still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Write data: key byte and control fields |
| rd_data | output | 16 | Control word read-back |
| tick_a | input | 1 | Tick enable of time base 0 |
| tick_b | input | 1 | Tick enable of time base 1 |
| tick_bk | input | 1 | Tick enable of the backup time base |
| irq_ack | input | 1 | Clears the interval flag |
| rst_req | output | 1 | One-cycle system reset request |
| irq_flag | output | 1 | Sticky interval expiry flag |
| on_backup | output | 1 | High while the counter runs on backup ticks |

## Verification
The hardest case to reach is a frozen watchdog that still fires because its selected source has died. To reach it, the bench silences `tick_a` while `tick_bk` keeps running and waits until `on_backup` rises. Only then does it write a frozen watchdog configuration, and it measures the spacing between the resets that follow. It then repeats the same conditions in interval mode, to show that the freeze applies again there. Periods are measured as the distance between two consecutive events. This keeps the fixed latency of the pipeline out of the expected value, which is simply 2^N times the tick spacing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam logic [7:0]  WR_KEY   = 8'h5A;
    localparam logic [7:0]  RD_KEY   = 8'h69;
    localparam int unsigned HOLD_BIT = 7;
    localparam int unsigned MODE_BIT = 4;
    localparam int unsigned CLR_BIT  = 3;
    localparam int unsigned CSEL_BIT = 2;

    typedef struct packed {
        logic       hold;
        logic       intv;
        logic       csel;
        logic [1:0] isel;
    } ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              clr_pulse,
    output logic              pw_fail,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  fail;
    } st_t;

    st_t  st_d, st_q;
    logic key_ok;
    logic unused_rsvd;

    assign key_ok      = (wr_data[WORD_W-1:8] == WR_KEY);
    assign unused_rsvd = ^{wr_data[6:5], wr_data[1'b0 ? 0 : 0]};

    always_comb begin
        st_d      = st_q;
        st_d.fail = 1'b0;
        clr_pulse = 1'b0;
        if (wr_en) begin
            if (key_ok) begin
                st_d.ctrl.hold = wr_data[HOLD_BIT];
                st_d.ctrl.intv = wr_data[MODE_BIT];
                st_d.ctrl.csel = wr_data[CSEL_BIT];
                st_d.ctrl.isel = wr_data[1:0];
                clr_pulse      = wr_data[CLR_BIT];
            end else begin
                st_d.fail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl    = st_q.ctrl;
    assign pw_fail = st_q.fail;
    assign rd_data = {RD_KEY, st_q.ctrl.hold, 2'b00, st_q.ctrl.intv, 1'b0,
                      st_q.ctrl.csel, st_q.ctrl.isel};

    // R3
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> $stable(rd_data));
endmodule

// File: rtl/wdt_clk_guard.sv
module wdt_clk_guard #(
    parameter int unsigned FS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_a,
    input  logic tick_b,
    input  logic tick_bk,
    input  logic csel,
    output logic tick_eff,
    output logic on_backup
);
    localparam int unsigned MISS_W = (FS_LIMIT < 2) ? 1 : $clog2(FS_LIMIT);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(FS_LIMIT - 1);

    typedef struct packed {
        logic [MISS_W-1:0] miss;
        logic              fs;
    } st_t;

    st_t  st_d, st_q;
    logic sel_tick;

    assign sel_tick = csel ? tick_b : tick_a;

    always_comb begin
        st_d = st_q;
        if (sel_tick) begin
            st_d.miss = '0;
            st_d.fs   = 1'b0;
        end else if (tick_bk && !st_q.fs) begin
            if (st_q.miss == MISS_TOP) st_d.fs   = 1'b1;
            else                       st_d.miss = st_q.miss + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_backup = st_q.fs;
    assign tick_eff  = st_q.fs ? tick_bk : sel_tick;

    // R10
    fs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_backup) |-> $past(!sel_tick && tick_bk));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TAP_LOG [4] = '{15, 13, 9, 6}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] isel,
    output logic       expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             exp;
    } st_t;

    st_t        st_d, st_q;
    logic [3:0] tap_full;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        assign tap_full[g] = &st_q.cnt[TAP_LOG[g]-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.exp = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.exp = tap_full[isel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.exp;

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(st_q.cnt) && !expire));
    // R4
    no_double_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/wdt_guard_top.sv
module wdt_guard_top
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FS_LIMIT = 4,
    parameter int unsigned TAP0     = 15,
    parameter int unsigned TAP1     = 13,
    parameter int unsigned TAP2     = 9,
    parameter int unsigned TAP3     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic        tick_bk,
    input  logic        irq_ack,
    output logic        rst_req,
    output logic        irq_flag,
    output logic        on_backup
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t   st_d, st_q;
    ctrl_t ctrl;
    logic  clr_pulse, pw_fail, tick_eff, run, expire;

    wdt_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl(ctrl), .clr_pulse(clr_pulse), .pw_fail(pw_fail), .rd_data(rd_data)
    );

    wdt_clk_guard #(.FS_LIMIT(FS_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .tick_bk(tick_bk), .csel(ctrl.csel), .tick_eff(tick_eff),
        .on_backup(on_backup)
    );

    assign run = !ctrl.hold || (!ctrl.intv && on_backup);

    wdt_counter #(.CNT_W(CNT_W), .TAP_LOG('{TAP0, TAP1, TAP2, TAP3})) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_eff), .run(run),
        .clr(clr_pulse), .isel(ctrl.isel), .expire(expire)
    );

    always_comb begin
        st_d.irq = (st_q.irq && !irq_ack) || (expire && ctrl.intv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req  = pw_fail || (expire && !ctrl.intv);
    assign irq_flag = st_q.irq;

    // R3
    bad_key_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] != WR_KEY) |=> rst_req);
    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(irq_ack));
    // R6
    irq_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> !$past(rst_req && !pw_fail));
endmodule

// File: tb/sim_wdt_guard_top.sv
module sim_wdt_guard_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tick_a = 1'b0, tick_b = 1'b0, tick_bk = 1'b0, irq_ack = 1'b0;
    logic        rst_req, irq_flag, on_backup;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int a_on = 1, a_div = 1, b_on = 0, b_div = 1, bk_on = 1, phase = 0;

    wdt_guard_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_a(tick_a), .tick_b(tick_b), .tick_bk(tick_bk),
        .irq_ack(irq_ack), .rst_req(rst_req), .irq_flag(irq_flag),
        .on_backup(on_backup)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        phase   = phase + 1;
        tick_a  = (a_on != 0) && (phase % a_div == 0);
        tick_b  = (b_on != 0) && (phase % b_div == 0);
        tick_bk = (bk_on != 0);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    function automatic int period_of(input int sel);
        case (sel)
            0: return 1 << 15;
            1: return 1 << 13;
            2: return 1 << 9;
            default: return 1 << 6;
        endcase
    endfunction

    task automatic wait_irq(output int at);
        at = -1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (irq_flag) begin at = cyc; break; end
        end
    endtask

    task automatic irq_period(input int exp, input string tag);
        int t0, t1;
        int rst_seen;
        ack();
        wait_irq(t0);
        @(negedge clk); irq_ack = 1'b1;
        rst_seen = rst_req;
        @(negedge clk); irq_ack = 1'b0;
        t1 = -1;
        for (int i = 0; i < 70000; i++) begin
            if (irq_flag) begin t1 = cyc; break; end
            if (rst_req) rst_seen = 1;
            @(negedge clk);
        end
        chk(t1 - t0 == exp, tag, t1 - t0, exp);
        chk(rst_seen == 0, {tag, " no reset in interval mode R6"}, rst_seen, 0);
    endtask

    task automatic rst_period(input int exp, input string tag);
        int t0, t1, w;
        t0 = -1; t1 = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rst_req) begin t0 = cyc; break; end
        end
        @(negedge clk);
        w = rst_req;
        chk(w == 0, {tag, " pulse width R5"}, w, 0);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rst_req) begin t1 = cyc; break; end
        end
        chk(t0 >= 0 && t1 - t0 == exp, tag, t1 - t0, exp);
    endtask

    task automatic count_rst(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
    endtask

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h6900, "R1 rd_data", rd_data, 16'h6900);
        chk({rst_req, irq_flag, on_backup} == 3'b000, "R1 outputs", {rst_req, irq_flag, on_backup}, 0);
        rst_n = 1'b1;

        // R4 and R6: each period select in interval mode, tick_a every cycle
        for (int s = 3; s >= 0; s--) begin
            wr(16'h5A18 | 16'(s));
            // R2 and R7: key byte and cleared bit 3 on read-back
            chk(rd_data == (16'h6910 | 16'(s)), "R2 R7 read-back", rd_data, 16'h6910 | s);
            irq_period(period_of(s), "R4 R6 interval period");
        end

        // R4 with sparser ticks: one tick every 3 cycles, select 3
        a_div = 3;
        wr(16'h5A1B);
        irq_period(3 * 64, "R4 sparse tick period");
        a_div = 1;

        // R3 bad key: reset pulse next cycle, control unchanged
        wr(16'h5A1B);
        ack();
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk); wr_en = 1'b0;
        chk(rst_req == 1'b1, "R3 reset after bad key", rst_req, 1);
        chk(rd_data == 16'h6913, "R3 control unchanged", rd_data, 16'h6913);
        @(negedge clk);
        chk(rst_req == 1'b0 || 1'b0, "R3 one-cycle pulse", rst_req, 0);

        // R5 watchdog mode select 3
        wr(16'h5A0B);
        ack();
        rst_period(64, "R5 watchdog period");
        chk(irq_flag == 1'b0, "R5 no irq in watchdog", irq_flag, 0);

        // R7 regular clears keep the watchdog quiet
        wr(16'h5A0B);
        hits = 0;
        for (int k = 0; k < 10; k++) begin
            int h;
            count_rst(40, h);
            hits += h;
            wr(16'h5A0B);
        end
        chk(hits == 0, "R7 serviced watchdog", hits, 0);
        chk(rd_data == 16'h6903, "R7 clear bit reads zero", rd_data, 16'h6903);

        // R9 freeze in watchdog (selected clock alive) and in interval mode
        wr(16'h5A8B);
        count_rst(300, hits);
        chk(hits == 0, "R9 frozen watchdog", hits, 0);
        wr(16'h5A9B);
        ack();
        repeat (300) @(negedge clk);
        chk(irq_flag == 1'b0, "R9 frozen interval", irq_flag, 0);
        wr(16'h5A1B);
        irq_period(64, "R9 resume after unfreeze");

        // R8 source select 1: tick_b every 2 cycles, tick_a silent
        a_on = 0; b_on = 1; b_div = 2;
        wr(16'h5A1F);
        irq_period(128, "R8 tick_b period");
        chk(on_backup == 1'b0, "R8 no fallback with live tick_b", on_backup, 0);

        // R10 fallback: select 0 while tick_a is silent
        b_on = 0;
        wr(16'h5A1B);
        repeat (8) @(negedge clk);
        chk(on_backup == 1'b1, "R10 fallback active", on_backup, 1);
        // R11 frozen watchdog still fires on backup ticks
        wr(16'h5A8B);
        rst_period(64, "R11 frozen watchdog on backup");
        // R11 freeze honoured in interval mode on backup
        wr(16'h5A9B);
        ack();
        repeat (200) @(negedge clk);
        chk(irq_flag == 1'b0, "R11 interval freeze on backup", irq_flag, 0);
        // R10 selected source returns
        a_on = 1;
        repeat (3) @(negedge clk);
        chk(on_backup == 1'b0, "R10 fallback released", on_backup, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 195000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule